// File: doc/BRIEF.md
# Pin Data Register with Shared Status Functions

This block holds the 32-bit configuration-space data register that owns a bank of nineteen general-purpose pins. A read of the register always returns the live pin levels after a two-stage synchronizer, whatever each pin is configured to do. A write changes the stored output value only for pins that are currently configured as outputs. Every other bit of the write is dropped.

Two pins can be handed to internal status logic instead of the stored value. The highest pin can carry either a presence-change summary or a hot-plug interrupt. The summary is the OR, across all downstream ports, of each port's "presence changed" flag ANDed with its enable. The pin below it can carry an over-power indication. That indication is raised while the fundamental port reset is active or while a slot power limit is exceeded. All three status sources are registered once before they reach a pin.

The block drives a per-pin output enable. It also accepts an initial latch value from a non-volatile loader through a one-cycle load strobe. The fundamental reset clears every register.

Top module: `gpio_pinreg`

## Requirements
- R1: While `frst_n` is low, the latch, synchronizer and status registers are zero. With every pin in output mode, `pin_out` and `rd_data` are 0.
- R2: When `cfg_addr` equals 0xC4, `rd_data[18:0]` shows `pin_in` as it was two rising edges earlier, in every pin mode. Any other address reads 0.
- R3: `rd_data[31:19]` is always 0, and writes to those bits change nothing.
- R4: A write (`cfg_wr` high, `cfg_addr` 0xC4) stores `cfg_wdata[i]` for each pin `i` whose mode is 2'b01 (output). That pin then drives the stored value on `pin_out[i]` from the next edge.
- R5: A pin in mode 2'b00 (input) keeps its stored bit across writes. Its `pin_oe` and `pin_out` bits are 0.
- R6: Pin 18 in mode 2'b10 drives, one edge late, the OR over ports `n` of `pd_changed[n] & pd_chg_en[n]`. Writes to bit 18 do not affect the pin.
- R7: Pin 18 in mode 2'b11 drives `hp_intr` delayed by one edge. Writes to bit 18 do not affect the pin.
- R8: Pin 17 in mode 2'b10 or 2'b11 drives, one edge late, `port_reset_act | pwr_limit_exc`. Writes to bit 17 do not affect the pin.
- R9: When `nv_load` is high at an edge, the latch takes `nv_data` for all pins. This takes priority over a simultaneous write.
- R10: `pin_oe[i]` is 1 for mode 2'b01, and also for modes 2'b1x on pins 17 and 18. Pins 0 to 16 in modes 2'b1x behave as inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| frst_n | input | 1 | Fundamental reset, active low, asynchronous |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data (combinational from address) |
| pin_mode | input | 38 | Two bits per pin; pin i at [2i+1:2i] |
| pin_in | input | 19 | Pin levels from pads |
| pin_out | output | 19 | Pin output values |
| pin_oe | output | 19 | Pin output enables |
| nv_load | input | 1 | Loader strobe |
| nv_data | input | 19 | Loader latch value |
| pd_changed | input | 4 | Per-port presence-changed flags |
| pd_chg_en | input | 4 | Per-port presence-changed enables |
| hp_intr | input | 1 | Hot-plug interrupt source |
| port_reset_act | input | 1 | Fundamental port reset active |
| pwr_limit_exc | input | 1 | Slot power limit exceeded |

## Verification
Read data follows the pins by two edges. Latch updates, loader values and the three status sources show up on `pin_out` one edge after the inputs that cause them. Output enables and the address decode for reads follow `pin_mode` and `cfg_addr` in the same cycle. The bench drives inputs at the falling edge and updates its reference model at the rising edge. It compares all outputs at the following falling edge, so each result is checked exactly in the cycle it is due. Directed cases pin down the two-edge read delay, the per-mode write masking and the load-over-write priority.

// File: rtl/gpio_pinreg_pkg.sv
package gpio_pinreg_pkg;
    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        MODE_IN    = 2'b00,
        MODE_OUT   = 2'b01,
        MODE_ALT_A = 2'b10,
        MODE_ALT_B = 2'b11
    } pin_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         frst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge frst_n) begin
        if (!frst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gpio_alt_status.sv
module gpio_alt_status #(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 frst_n,
    input  logic [NUM_PORTS-1:0] pd_changed,
    input  logic [NUM_PORTS-1:0] pd_chg_en,
    input  logic                 hp_intr,
    input  logic                 port_reset_act,
    input  logic                 pwr_limit_exc,
    output logic                 pdc_sum,
    output logic                 hp_sum,
    output logic                 ovp_sum
);
    typedef struct packed {
        logic pdc;
        logic hp;
        logic ovp;
    } alt_t;

    alt_t st_d, st_q;
    logic [NUM_PORTS-1:0] port_hit;

    always_comb begin
        port_hit = pd_changed & pd_chg_en;
        st_d     = st_q;
        st_d.pdc = |port_hit;
        st_d.hp  = hp_intr;
        st_d.ovp = port_reset_act | pwr_limit_exc;
    end

    always_ff @(posedge clk or negedge frst_n) begin
        if (!frst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pdc_sum = st_q.pdc;
    assign hp_sum  = st_q.hp;
    assign ovp_sum = st_q.ovp;

    // R6
    pdc_follow_chk: assert property (@(posedge clk) disable iff (!frst_n)
        (|(pd_changed & pd_chg_en)) |=> pdc_sum);
    // R6
    pdc_quiet_chk: assert property (@(posedge clk) disable iff (!frst_n)
        !(|(pd_changed & pd_chg_en)) |=> !pdc_sum);
    // R7
    hp_follow_chk: assert property (@(posedge clk) disable iff (!frst_n)
        hp_intr |=> hp_sum);
    // R8
    ovp_reset_chk: assert property (@(posedge clk) disable iff (!frst_n)
        port_reset_act |=> ovp_sum);
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_pinreg_pkg::*;
#(
    parameter int PIN_W   = 19,
    parameter int PDC_PIN = 18,
    parameter int OVP_PIN = 17
) (
    input  logic [2*PIN_W-1:0] pin_mode,
    input  logic [PIN_W-1:0]   latch,
    input  logic               pdc_sum,
    input  logic               hp_sum,
    input  logic               ovp_sum,
    output logic [PIN_W-1:0]   pin_out,
    output logic [PIN_W-1:0]   pin_oe,
    output logic [PIN_W-1:0]   out_mask
);
    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        pin_mode_e m;
        logic      val;
        logic      oe;
        always_comb begin
            m   = pin_mode_e'(pin_mode[2*i +: 2]);
            val = 1'b0;
            oe  = 1'b0;
            if (m == MODE_OUT) begin
                val = latch[i];
                oe  = 1'b1;
            end else if (m != MODE_IN) begin
                if (i == PDC_PIN) begin
                    val = (m == MODE_ALT_A) ? pdc_sum : hp_sum;
                    oe  = 1'b1;
                end else if (i == OVP_PIN) begin
                    val = ovp_sum;
                    oe  = 1'b1;
                end
            end
        end
        assign pin_out[i]  = oe & val;
        assign pin_oe[i]   = oe;
        assign out_mask[i] = (m == MODE_OUT);
    end
endmodule

// File: rtl/gpio_pinreg.sv
module gpio_pinreg
    import gpio_pinreg_pkg::*;
#(
    parameter int          PIN_W      = 19,
    parameter int          NUM_PORTS  = 4,
    parameter int          ADDR_W     = 8,
    parameter logic [7:0]  REG_OFFSET = 8'hC4,
    parameter int          PDC_PIN    = 18,
    parameter int          OVP_PIN    = 17
) (
    input  logic                 clk,
    input  logic                 frst_n,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic                 cfg_wr,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     rd_data,
    input  logic [2*PIN_W-1:0]   pin_mode,
    input  logic [PIN_W-1:0]     pin_in,
    output logic [PIN_W-1:0]     pin_out,
    output logic [PIN_W-1:0]     pin_oe,
    input  logic                 nv_load,
    input  logic [PIN_W-1:0]     nv_data,
    input  logic [NUM_PORTS-1:0] pd_changed,
    input  logic [NUM_PORTS-1:0] pd_chg_en,
    input  logic                 hp_intr,
    input  logic                 port_reset_act,
    input  logic                 pwr_limit_exc
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

    typedef struct packed {
        logic [PIN_W-1:0] latch;
    } reg_t;

    reg_t             st_d, st_q;
    logic [PIN_W-1:0] pin_sync;
    logic [PIN_W-1:0] out_mask;
    logic [PIN_W-1:0] wr_mask;
    logic             addr_hit;
    logic             pdc_sum, hp_sum, ovp_sum;

    gpio_sync #(.W(PIN_W)) u_sync (
        .clk      (clk),
        .frst_n   (frst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_alt_status #(.NUM_PORTS(NUM_PORTS)) u_alt (
        .clk            (clk),
        .frst_n         (frst_n),
        .pd_changed     (pd_changed),
        .pd_chg_en      (pd_chg_en),
        .hp_intr        (hp_intr),
        .port_reset_act (port_reset_act),
        .pwr_limit_exc  (pwr_limit_exc),
        .pdc_sum        (pdc_sum),
        .hp_sum         (hp_sum),
        .ovp_sum        (ovp_sum)
    );

    gpio_pin_mux #(.PIN_W(PIN_W), .PDC_PIN(PDC_PIN), .OVP_PIN(OVP_PIN)) u_mux (
        .pin_mode (pin_mode),
        .latch    (st_q.latch),
        .pdc_sum  (pdc_sum),
        .hp_sum   (hp_sum),
        .ovp_sum  (ovp_sum),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .out_mask (out_mask)
    );

    always_comb begin
        addr_hit = (cfg_addr == HIT_ADDR);
        wr_mask  = (cfg_wr && addr_hit) ? out_mask : '0;
        st_d     = st_q;
        if (nv_load)
            st_d.latch = nv_data;
        else
            st_d.latch = (st_q.latch & ~wr_mask) | (cfg_wdata[PIN_W-1:0] & wr_mask);
    end

    always_ff @(posedge clk or negedge frst_n) begin
        if (!frst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (addr_hit) rd_data[PIN_W-1:0] = pin_sync;
    end

    // R4 R5
    masked_write_chk: assert property (@(posedge clk) disable iff (!frst_n)
        !nv_load |=> ((st_q.latch ^ $past(st_q.latch)) & ~$past(wr_mask)) == '0);
    // R9
    nv_load_chk: assert property (@(posedge clk) disable iff (!frst_n)
        nv_load |=> st_q.latch == $past(nv_data));
    // R3
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!frst_n)
        cfg_wr |=> rd_data[REG_W-1:PIN_W] == '0);
endmodule

// File: tb/gpio_pinreg_tb.sv
module gpio_pinreg_tb;
    localparam int PW = 19;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          frst_n = 1'b0;
    logic [7:0]    cfg_addr = 8'hC4;
    logic          cfg_wr = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   rd_data;
    logic [2*PW-1:0] pin_mode = {PW{2'b01}};
    logic [PW-1:0] pin_in = '0;
    logic [PW-1:0] pin_out, pin_oe;
    logic          nv_load = 1'b0;
    logic [PW-1:0] nv_data = '0;
    logic [NP-1:0] pd_changed = '0, pd_chg_en = '0;
    logic          hp_intr = 1'b0, port_reset_act = 1'b0, pwr_limit_exc = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    gpio_pinreg u_dut (
        .clk(clk), .frst_n(frst_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .rd_data(rd_data), .pin_mode(pin_mode),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .nv_load(nv_load),
        .nv_data(nv_data), .pd_changed(pd_changed), .pd_chg_en(pd_chg_en),
        .hp_intr(hp_intr), .port_reset_act(port_reset_act), .pwr_limit_exc(pwr_limit_exc)
    );

    // reference model state
    logic [PW-1:0] m_latch = '0, m_s1 = '0, m_s2 = '0;
    logic m_pdc = 0, m_hp = 0, m_ovp = 0;

    function automatic logic [1:0] mode_of(int i);
        return pin_mode[2*i +: 2];
    endfunction

    function automatic logic [PW-1:0] exp_oe();
        logic [PW-1:0] r = '0;
        for (int i = 0; i < PW; i++) begin
            logic [1:0] m = mode_of(i);
            r[i] = (m == 2'b01) || (m[1] && (i == 17 || i == 18));
        end
        return r;
    endfunction

    function automatic logic [PW-1:0] exp_out();
        logic [PW-1:0] r = '0;
        logic [PW-1:0] oe = exp_oe();
        for (int i = 0; i < PW; i++) begin
            logic [1:0] m = mode_of(i);
            logic v;
            if (m == 2'b01)        v = m_latch[i];
            else if (i == 18)      v = (m == 2'b10) ? m_pdc : m_hp;
            else                   v = m_ovp;
            r[i] = oe[i] & v;
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_rd();
        return (cfg_addr == 8'hC4) ? {13'b0, m_s2} : 32'h0;
    endfunction

    task automatic model_edge();
        if (!frst_n) begin
            m_latch = '0; m_s1 = '0; m_s2 = '0; m_pdc = 0; m_hp = 0; m_ovp = 0;
        end else begin
            logic [PW-1:0] msk = '0;
            for (int i = 0; i < PW; i++) msk[i] = (mode_of(i) == 2'b01);
            m_s2 = m_s1; m_s1 = pin_in;
            m_pdc = |(pd_changed & pd_chg_en); m_hp = hp_intr;
            m_ovp = port_reset_act | pwr_limit_exc;
            if (nv_load) m_latch = nv_data;
            else if (cfg_wr && cfg_addr == 8'hC4)
                m_latch = (m_latch & ~msk) | (cfg_wdata[PW-1:0] & msk);
        end
    endtask

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "rd_data", rd_data, exp_rd());
        chk(tag, "pin_out", 32'(pin_out), 32'(exp_out()));
        chk(tag, "pin_oe", 32'(pin_oe), 32'(exp_oe()));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1 reset state
        pin_in = '1; cfg_wr = 1; cfg_wdata = '1;
        step("R1"); step("R1");
        chk("R1", "pin_out in reset", 32'(pin_out), 0);
        chk("R1", "rd_data in reset", rd_data, 0);
        cfg_wr = 0; pin_in = '0;
        frst_n = 1;
        step("R1");
        chk("R1", "pin_out after reset", 32'(pin_out), 0);

        // R4 write, R2 two-edge latency, R3 reserved bits
        cfg_wr = 1; cfg_wdata = 32'hFFFF_FFFF; pin_in = '1;
        step("R4");
        chk("R4", "pin_out after write", 32'(pin_out), 32'h0007_FFFF);
        cfg_wr = 0;
        chk("R2", "rd one edge", rd_data, 32'h0);
        step("R2");
        chk("R2", "rd two edges", rd_data, 32'h0007_FFFF);
        chk("R3", "reserved read", {rd_data[31:19], 19'h0}, 32'h0);
        cfg_addr = 8'hC0;
        step("R2");
        chk("R2", "other address", rd_data, 32'h0);
        cfg_addr = 8'hC4;

        // R5 input mode keeps latch
        pin_mode[7:6] = 2'b00; cfg_wr = 1; cfg_wdata = 32'h0;
        step("R5");
        chk("R5", "input pin oe", 32'(pin_oe[3]), 0);
        chk("R5", "pin_out", 32'(pin_out), 32'h0000_0000);
        cfg_wr = 0; pin_mode[7:6] = 2'b01;
        step("R5");
        chk("R5", "kept latch", 32'(pin_out), 32'h0000_0008);

        // R6 presence-change summary
        pin_mode[37:36] = 2'b10; pd_changed = 4'b0001; pd_chg_en = 4'b0010;
        cfg_wr = 1; cfg_wdata = 32'h0004_0000;
        step("R6");
        chk("R6", "no match", 32'(pin_out[18]), 0);
        cfg_wr = 0; pd_chg_en = 4'b0011;
        step("R6");
        chk("R6", "match", 32'(pin_out[18]), 1);
        pd_changed = 4'b1000; pd_chg_en = 4'b1000;
        step("R6");

        // R7 hot-plug interrupt
        pin_mode[37:36] = 2'b11; hp_intr = 1; cfg_wr = 1; cfg_wdata = 32'h0;
        step("R7");
        chk("R7", "hp high", 32'(pin_out[18]), 1);
        hp_intr = 0; cfg_wr = 1; cfg_wdata = 32'h0004_0000;
        step("R7");
        chk("R7", "hp low", 32'(pin_out[18]), 0);
        cfg_wr = 0;

        // R8 over-power
        pin_mode[35:34] = 2'b10; port_reset_act = 1;
        step("R8");
        chk("R8", "reset active", 32'(pin_out[17]), 1);
        port_reset_act = 0; pwr_limit_exc = 1; pin_mode[35:34] = 2'b11;
        step("R8");
        chk("R8", "limit", 32'(pin_out[17]), 1);
        pwr_limit_exc = 0;
        step("R8");
        chk("R8", "idle", 32'(pin_out[17]), 0);

        // R9 load beats write
        pin_mode = {PW{2'b01}}; nv_load = 1; nv_data = 19'h5A5A5;
        cfg_wr = 1; cfg_wdata = 32'h0;
        step("R9");
        chk("R9", "loaded", 32'(pin_out), 32'h0005_A5A5);
        nv_load = 0; cfg_wr = 0;

        // R10 enables for alternate codes
        pin_mode[11:10] = 2'b10; pin_mode[35:34] = 2'b11; pin_mode[37:36] = 2'b00;
        step("R10");
        chk("R10", "pin5 alt is input", 32'(pin_oe[5]), 0);
        chk("R10", "pin17 alt drives", 32'(pin_oe[17]), 1);
        chk("R10", "pin18 input", 32'(pin_oe[18]), 0);

        // random mix, R2 R4 R6 R7 R8 R9 R10 against model
        void'($urandom(32'd1234));
        for (int k = 0; k < 3000; k++) begin
            cfg_addr = ($urandom % 4 != 0) ? 8'hC4 : 8'($urandom);
            cfg_wr = $urandom % 2;
            cfg_wdata = $urandom;
            if ($urandom % 8 == 0) pin_mode = {$urandom, $urandom};
            pin_in = PW'($urandom);
            nv_load = ($urandom % 16 == 0);
            nv_data = PW'($urandom);
            pd_changed = NP'($urandom); pd_chg_en = NP'($urandom);
            hp_intr = $urandom % 2; port_reset_act = ($urandom % 4 == 0);
            pwr_limit_exc = ($urandom % 4 == 0);
            step("R2/R4 random");
        end
        finish_run();
    end
endmodule